// File: doc/BRIEF.md
# Palette Entry Format Converter

This block turns raw palette words into a uniform colour entry of 8 bits for each of red, green and blue, plus a transparency flag, and keeps the converted entries in an internal palette RAM indexed by pixel value. A load begins with a `load_start` pulse. That pulse fixes three things for the whole load: the layout, the monochrome flag and the entry count. Raw words then stream in through a valid/ready handshake. A registered read port lets the pixel side look up any entry.

There are four layouts. Layout 0 is a packed 16-bit 5:6:5 word. Layouts 1 to 3 are 32-bit words with a transparency bit, holding 16-bit, 18-bit or 24-bit colour. Bits 31:25 of a fetched word carry nothing, so the input holds only the low 25 bits. The layout select is the 2-bit field at bits 16:15 of the display control word. A neighbouring block decodes that field and drives it onto `fmt_sel`. The block compares this field with the value used for the last load, and raises a reload request whenever the two differ.

Back-pressure: `in_ready` is high only while a load is active. A word moves only in a cycle where `in_valid` and `in_ready` are both high and `load_start` is low. The source may hold `in_valid` low for any number of cycles between words. When `in_ready` is low, the source must keep its word.

Top module: `pal_conv_top`

## Requirements
- R1: With layout 0 and monochrome off, the entry is red={in[15:11],000}, green={in[10:5],00}, blue={in[4:0],000}, and transparency is 0.
- R2: With layout 1 and monochrome off, red={in[23:19],000}, green={in[15:10],00}, blue={in[7:3],000}.
- R3: With layout 2 and monochrome off, red={in[23:18],00}, green={in[15:10],00}, blue={in[7:2],00}.
- R4: With layout 3 and monochrome off, red=in[23:16], green=in[15:8], blue=in[7:0].
- R5: Transparency is in[24] for layouts 1 to 3 and 0 for layout 0, whether monochrome is on or off.
- R6: With monochrome on, red, green and blue all equal in[7:0], for every layout.
- R7: `depth_sel` values 0, 1, 2 and 3 give a load of 2, 4, 16 and 256 entries. `in_ready` falls in the cycle after the last entry is accepted.
- R8: `load_start` restarts the write index at 0, even during a load. A word presented in the same cycle as `load_start` is discarded.
- R9: `load_done` is high for exactly one cycle: the cycle after the last entry of a load is accepted.
- R10: `reload_req` is high from reset until the first load. After that it is high whenever `fmt_sel` differs from the value captured at the latest `load_start`.
- R11: `rd_data` presents the entry at `rd_idx` one cycle later, packed {transparency, red, green, blue}. A read of the index written at the same edge returns the previous content. After reset, `rd_data` is 0.
- R12: While no load is active, `in_ready` is low and words offered on `in_valid` change no entry.
- R13: The layout and monochrome flag captured at `load_start` apply to the whole load. Changes to `fmt_sel` or `mono` in the middle of a load do not alter the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Palette layout field (control word bits 16:15) |
| mono | input | 1 | Monochrome override request |
| depth_sel | input | 2 | Entry count select: 2, 4, 16 or 256 entries |
| load_start | input | 1 | Begins a palette load |
| in_valid | input | 1 | Raw word valid |
| in_ready | output | 1 | Block accepts a raw word |
| in_data | input | 25 | Raw palette word, bits 24:0 |
| load_done | output | 1 | One-cycle pulse after the last entry |
| reload_req | output | 1 | Palette must be reparsed before the next frame |
| rd_idx | input | 8 | Lookup index |
| rd_data | output | 25 | Entry {transparency, red, green, blue} |

## Verification
The hardest situations to reach from the ports involve contention inside one load: a second `load_start` that arrives in the same cycle as a valid word, and layout or monochrome inputs that change while words are still streaming in. The stimulus aborts a 16-entry load after three words by raising `load_start` together with `in_valid`. It also flips `fmt_sel` and `mono` after the first word of another load. Later sweeps of the read port then show the discarded word and the layout that was kept. A separate load keeps `rd_idx` on index 0 to exercise the read-before-write collision.

// File: rtl/pal_conv_pkg.sv
package pal_conv_pkg;
  localparam int RAW_W      = 25;
  localparam int CH_W       = 8;
  localparam int ENTRY_W    = 3 * CH_W + 1;
  localparam int TRANSP_BIT = 24;

  typedef enum logic [1:0] {
    FMT_565   = 2'd0,
    FMT_T565  = 2'd1,
    FMT_T666  = 2'd2,
    FMT_T888  = 2'd3
  } pal_fmt_e;

  typedef struct packed {
    logic            t;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } pal_entry_t;

  // Last write index for a given entry-count select: 2^(2^sel) - 1
  function automatic logic [8:0] last_index9(input logic [1:0] sel);
    logic [8:0] v;
    unique case (sel)
      2'd0:    v = 9'd1;
      2'd1:    v = 9'd3;
      2'd2:    v = 9'd15;
      default: v = 9'd255;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pal_field_unpack.sv
module pal_field_unpack
  import pal_conv_pkg::*;
(
  input  pal_fmt_e         fmt,
  input  logic             mono,
  input  logic [RAW_W-1:0] raw,
  output pal_entry_t       ent
);
  always_comb begin
    ent   = '0;
    ent.t = (fmt == FMT_565) ? 1'b0 : raw[TRANSP_BIT];
    unique case (fmt)
      FMT_565: begin
        ent.r = {raw[15:11], 3'b000};
        ent.g = {raw[10:5], 2'b00};
        ent.b = {raw[4:0], 3'b000};
      end
      FMT_T565: begin
        ent.r = {raw[23:19], 3'b000};
        ent.g = {raw[15:10], 2'b00};
        ent.b = {raw[7:3], 3'b000};
      end
      FMT_T666: begin
        ent.r = {raw[23:18], 2'b00};
        ent.g = {raw[15:10], 2'b00};
        ent.b = {raw[7:2], 2'b00};
      end
      default: begin
        ent.r = raw[23:16];
        ent.g = raw[15:8];
        ent.b = raw[7:0];
      end
    endcase
    if (mono) begin
      ent.r = raw[7:0];
      ent.g = raw[7:0];
      ent.b = raw[7:0];
    end
  end
endmodule

// File: rtl/pal_load_seq.sv
module pal_load_seq
  import pal_conv_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic [1:0]       depth_sel,
  input  pal_fmt_e         fmt_in,
  input  logic             mono_in,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             load_done,
  output pal_fmt_e         fmt_q,
  output logic             mono_q
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [8:0]       last_full;
  logic             done_q;

  assign last_full = last_index9(depth_sel);
  assign in_ready  = busy_q;
  assign wr_en     = busy_q & in_valid & ~load_start;
  assign wr_idx    = idx_q;
  assign load_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
      fmt_q  <= FMT_565;
      mono_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        last_q <= last_full[IDX_W-1:0];
        fmt_q  <= fmt_in;
        mono_q <= mono_in;
      end else if (wr_en) begin
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pal_fmt_watch.sv
module pal_fmt_watch
  import pal_conv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_start,
  input  pal_fmt_e fmt_in,
  output logic     reload_req
);
  pal_fmt_e used_q;
  logic     seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= FMT_565;
      seen_q <= 1'b0;
    end else if (load_start) begin
      used_q <= fmt_in;
      seen_q <= 1'b1;
    end
  end

  assign reload_req = ~seen_q | (fmt_in != used_q);
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8,
  parameter int W     = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_conv_top.sv
module pal_conv_top
  import pal_conv_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         fmt_sel,
  input  logic               mono,
  input  logic [1:0]         depth_sel,
  input  logic               load_start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RAW_W-1:0]   in_data,
  output logic               load_done,
  output logic               reload_req,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  pal_fmt_e         fmt_live;
  pal_fmt_e         fmt_q;
  logic             mono_q;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  pal_entry_t       conv_ent;

  assign fmt_live = pal_fmt_e'(fmt_sel);

  pal_load_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .depth_sel  (depth_sel),
    .fmt_in     (fmt_live),
    .mono_in    (mono),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .load_done  (load_done),
    .fmt_q      (fmt_q),
    .mono_q     (mono_q)
  );

  pal_field_unpack u_unpack (
    .fmt  (fmt_q),
    .mono (mono_q),
    .raw  (in_data),
    .ent  (conv_ent)
  );

  pal_fmt_watch u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .fmt_in     (fmt_live),
    .reload_req (reload_req)
  );

  pal_ram #(.IDX_W(IDX_W), .W(ENTRY_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (conv_ent),
    .raddr (rd_idx),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pal_conv_checks.sv
module pal_conv_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fmt_sel,
  input logic       load_start,
  input logic       in_valid,
  input logic       in_ready,
  input logic       load_done,
  input logic       reload_req
);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_done_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(in_valid && in_ready && !load_start));

  p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !in_ready);

  p_start_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> in_ready);

  p_reload_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> (reload_req == (fmt_sel != $past(fmt_sel))));

  p_idle_no_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !load_start) |=> !load_done);
endmodule

bind pal_conv_top pal_conv_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_sel    (fmt_sel),
  .load_start (load_start),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .load_done  (load_done),
  .reload_req (reload_req)
);

// File: tb/pal_conv_top_tb.sv
module pal_conv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        mono = 1'b0;
  logic [1:0]  depth_sel = 2'd0;
  logic        load_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [24:0] in_data = '0;
  logic        load_done;
  logic        reload_req;
  logic [7:0]  rd_idx = '0;
  logic [24:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R11";

  pal_conv_top dut_i (.*);

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [24:0] m_mem [256];
  bit          m_known [256];
  bit          m_busy, m_done, m_used_vld, m_mono, m_rd_known;
  int          m_idx, m_last, m_fmt, m_used_fmt;
  logic [24:0] m_rd;

  function automatic logic [24:0] ref_conv(int f, bit mo, logic [24:0] d);
    int r, g, b, t;
    t = (f == 0) ? 0 : int'(d[24]);
    case (f)
      0: begin r = ((d >> 11) % 32) * 8; g = ((d >> 5) % 64) * 4; b = (d % 32) * 8; end
      1: begin r = ((d >> 19) % 32) * 8; g = ((d >> 10) % 64) * 4; b = ((d >> 3) % 32) * 8; end
      2: begin r = ((d >> 18) % 64) * 4; g = ((d >> 10) % 64) * 4; b = ((d >> 2) % 64) * 4; end
      default: begin r = (d >> 16) % 256; g = (d >> 8) % 256; b = d % 256; end
    endcase
    if (mo) begin r = d % 256; g = r; b = r; end
    return 25'(t * 16777216 + r * 65536 + g * 256 + b);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_used_vld = 0; m_idx = 0; m_last = 0;
      m_rd = '0; m_rd_known = 1;
    end else begin
      m_rd_known = m_known[rd_idx];
      m_rd = m_mem[rd_idx];
      m_done = 0;
      if (load_start) begin
        m_busy = 1; m_idx = 0;
        m_last = (1 << (1 << depth_sel)) - 1;
        m_fmt = fmt_sel; m_mono = mono;
        m_used_fmt = fmt_sel; m_used_vld = 1;
      end else if (m_busy && in_valid) begin
        m_mem[m_idx] = ref_conv(m_fmt, m_mono, in_data);
        m_known[m_idx] = 1;
        if (m_idx == m_last) begin m_busy = 0; m_done = 1; end
        else m_idx++;
      end
    end
  end

  task automatic chk(string req, string what, logic [24:0] act, logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit exp_reload;
    exp_reload = !m_used_vld || (int'(fmt_sel) != m_used_fmt);
    chk("R7", "in_ready", 25'(in_ready), 25'(m_busy));
    chk("R9", "load_done", 25'(load_done), 25'(m_done));
    chk("R10", "reload_req", 25'(reload_req), 25'(exp_reload));
    if (m_rd_known) chk(cur_req, "rd_data", rd_data, m_rd);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [24:0] gen(int i, int seed);
    int unsigned v;
    v = (i + 1) * 32'h9E3779B1 + seed * 32'h85EBCA6B;
    v = v ^ (v >> 13);
    return v[24:0];
  endfunction

  task automatic do_load(int f, bit mo, int dsel, int seed, bit gaps);
    int n;
    n = 1 << (1 << dsel);
    fmt_sel = 2'(f); mono = mo; depth_sel = 2'(dsel);
    load_start = 1; in_valid = 0;
    step();
    load_start = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin in_valid = 0; step(); end
      in_valid = 1; in_data = gen(i, seed);
      step();
    end
    in_valid = 0;
    step();
  endtask

  task automatic read_all(int n);
    in_valid = 0;
    for (int i = 0; i < n; i++) begin rd_idx = 8'(i); step(); end
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state: R11 rd_data 0, R10 reload high, R12 ready low
    cur_req = "R11";
    chk("R11", "rd_data after reset", rd_data, '0);
    chk("R10", "reload after reset", 25'(reload_req), 25'd1);
    chk("R12", "in_ready after reset", 25'(in_ready), 25'd0);

    cur_req = "R1";  do_load(0, 0, 1, 1, 0); read_all(4);
    cur_req = "R2";  do_load(1, 0, 0, 2, 0); read_all(2);
    cur_req = "R3";  do_load(2, 0, 2, 3, 1); read_all(16);
    cur_req = "R4";  do_load(3, 0, 3, 4, 1); read_all(256);
    cur_req = "R5";  do_load(1, 0, 2, 5, 0); read_all(16);
    cur_req = "R6";  do_load(0, 1, 2, 6, 0); read_all(16);
    cur_req = "R6";  do_load(3, 1, 2, 7, 0); read_all(16);

    // R8: abort mid-load with a word offered in the load_start cycle
    cur_req = "R8";
    fmt_sel = 2'd3; mono = 0; depth_sel = 2'd2;
    load_start = 1; step(); load_start = 0;
    for (int i = 0; i < 3; i++) begin in_valid = 1; in_data = gen(i, 8); step(); end
    load_start = 1; in_valid = 1; in_data = 25'h1FFFFFF; step();
    load_start = 0;
    for (int i = 0; i < 16; i++) begin in_valid = 1; in_data = gen(i, 9); step(); end
    in_valid = 0; step();
    read_all(16);

    // R13: inputs change mid-load
    cur_req = "R13";
    fmt_sel = 2'd2; mono = 0; depth_sel = 2'd2;
    load_start = 1; step(); load_start = 0;
    for (int i = 0; i < 16; i++) begin
      in_valid = 1; in_data = gen(i, 10); step();
      if (i == 0) begin fmt_sel = 2'd0; mono = 1; end
    end
    in_valid = 0; step();
    read_all(16);

    // R10: format change while idle, then back
    fmt_sel = 2'd1; step();
    chk("R10", "reload on change", 25'(reload_req), 25'd1);
    fmt_sel = 2'd2; step();
    chk("R10", "reload cleared on match", 25'(reload_req), 25'd0);

    // R11: read the index being written
    cur_req = "R11";
    rd_idx = 8'd0;
    do_load(3, 0, 1, 11, 0);
    read_all(4);

    // R12: words offered while idle are ignored
    cur_req = "R12";
    for (int i = 0; i < 8; i++) begin
      in_valid = 1; in_data = gen(i, 12); rd_idx = 8'(i); step();
      chk("R12", "in_ready idle", 25'(in_ready), 25'd0);
    end
    read_all(8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule